// File: doc/BRIEF.md
# Boot Sector Write Guard with Identification Readout

This block sits between the command decoder of a byte-wide flash controller and the array controller. It keeps a one-way protection flag for the lowest 8K-byte sector of a 64K-byte space. Every program or erase request from the decoder passes through it. A byte program aimed at the protected sector is dropped once the flag is set. A chip erase is always passed on, and a separate mask output tells the array controller to leave the protected sector intact.

The same block also drives the read data path. In normal operation it forwards array data. While the decoder signals identification mode, it returns the manufacturer code, the device code and the protection state in place of array data. Only a power-on reset clears the protection flag; this models a blank part. The functional soft reset empties the output registers and leaves the flag unchanged.

Top module: `bootlock_guard`

## Requirements
- R1: The protected window is byte addresses 16'h0000 to 16'h1FFF inclusive. Address 16'h2000 and above are outside it.
- R2: While `por` is high at a clock edge, the lock flag clears. From the next cycle, `erase_mask`, `gnt_valid` and `rd_data` read 0.
- R3: A `lock_set` pulse sampled at a clock edge raises `erase_mask` from the next cycle. The mask then stays high through soft resets and further strobes until the next `por`.
- R4: When `req_valid` is high with `req_erase`=0 (a byte program) at an address inside the window, and the flag held before that edge is set, `gnt_valid` is 0 in the next cycle.
- R5: A byte program outside the window, or any program while the flag is clear, appears on `gnt_valid`/`gnt_addr`/`gnt_data`/`gnt_erase` exactly one cycle later.
- R6: A request with `req_erase`=1 (chip erase) is always forwarded one cycle later with `gnt_erase`=1, whatever the lock state.
- R7: With `id_mode` low, `rd_data` equals the `arr_rd_data` sampled at the previous edge.
- R8: With `id_mode` high, `rd_addr` 0 yields 8'h1F and `rd_addr` 1 yields 8'h03 on `rd_data` one cycle later.
- R9: With `id_mode` high, `rd_addr` 2 yields the flag held before that edge on bit 0 (1 = locked), with bits 7:1 zero.
- R10: With `id_mode` high, every other `rd_addr` yields 8'h00.
- R11: A `srst` sampled at an edge forces `gnt_valid` and `rd_data` to 0 in the next cycle and does not change the lock flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; also clears the lock flag |
| srst | input | 1 | Functional soft reset, synchronous, active high; keeps the lock flag |
| lock_set | input | 1 | One-cycle strobe that sets the protection flag |
| id_mode | input | 1 | Identification mode active |
| rd_addr | input | 16 | Read address |
| arr_rd_data | input | 8 | Data read from the array |
| req_valid | input | 1 | Program or erase request present |
| req_erase | input | 1 | 1 = chip erase, 0 = byte program |
| req_addr | input | 16 | Program address |
| req_data | input | 8 | Program data |
| gnt_valid | output | 1 | Request forwarded to the array controller |
| gnt_erase | output | 1 | Forwarded request is a chip erase |
| gnt_addr | output | 16 | Forwarded address |
| gnt_data | output | 8 | Forwarded data |
| erase_mask | output | 1 | Protected sector must be retained during erase |
| rd_data | output | 8 | Read data, either array data or identification word |

## Verification
Each result has a fixed latency. The forwarded request and the read word each come out one cycle after their inputs are sampled. The mask responds to a strobe, or to a power-on reset, in the cycle after that edge. The driver applies one set of inputs on each falling edge. It queues the values expected after the next rising edge, and the monitor compares them 5 ns after that edge. Each queued entry is therefore matched against the exact cycle in which its effect is due. The protection decision uses the flag held before the edge. So a strobe and a program in the same cycle show the program passing, and the expected values are built the same way.

// File: rtl/bootlock_pkg.sv
package bootlock_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int PROT_BYTES = 8192;

    localparam logic [ADDR_W-1:0] PROT_LIMIT    = ADDR_W'(PROT_BYTES);
    localparam logic [ADDR_W-1:0] ID_MFR_ADDR   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ID_DEV_ADDR   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ID_LOCK_ADDR  = ADDR_W'(2);
    localparam logic [DATA_W-1:0] MFR_CODE      = 8'h1F;
    localparam logic [DATA_W-1:0] DEV_CODE      = 8'h03;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return a < PROT_LIMIT;
    endfunction

    function automatic logic [DATA_W-1:0] id_word(input logic [ADDR_W-1:0] a,
                                                  input logic              locked);
        logic [DATA_W-1:0] w;
        w = '0;
        if (a == ID_MFR_ADDR)       w = MFR_CODE;
        else if (a == ID_DEV_ADDR)  w = DEV_CODE;
        else if (a == ID_LOCK_ADDR) w = {{(DATA_W-1){1'b0}}, locked};
        return w;
    endfunction

endpackage

// File: rtl/bootlock_flag.sv
module bootlock_flag (
    input  logic clk,
    input  logic por,
    input  logic set_i,
    output logic locked_o
);
    always_ff @(posedge clk) begin
        if (por)        locked_o <= 1'b0;
        else if (set_i) locked_o <= 1'b1;
    end

    // R3: once set, only power-on reset clears the flag
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (por)
        locked_o |=> locked_o);

    // R3: a strobe always leaves the flag set
    a_r3_set_takes: assert property (@(posedge clk) disable iff (por)
        set_i |=> locked_o);
endmodule

// File: rtl/bootlock_req_gate.sv
module bootlock_req_gate
    import bootlock_pkg::*;
(
    input  logic clk,
    input  logic por,
    input  logic srst,
    input  logic locked_i,
    input  logic req_valid_i,
    input  req_t req_i,
    output logic gnt_valid_o,
    output req_t gnt_o
);
    logic blocked;

    always_comb begin
        blocked = locked_i && (req_i.op == OP_PROGRAM) && in_window(req_i.addr);
    end

    always_ff @(posedge clk) begin
        if (por || srst) begin
            gnt_valid_o <= 1'b0;
            gnt_o       <= '0;
        end else begin
            gnt_valid_o <= req_valid_i && !blocked;
            if (req_valid_i) gnt_o <= req_i;
        end
    end

    // R4: a program into the locked window never reaches the array
    a_r4_no_locked_program: assert property (@(posedge clk) disable iff (por || srst)
        (req_valid_i && req_i.op == OP_PROGRAM && locked_i && req_i.addr < PROT_LIMIT)
        |=> !gnt_valid_o);

    // R5: programs outside the window pass with address and data intact
    a_r5_outside_passes: assert property (@(posedge clk) disable iff (por || srst)
        (req_valid_i && req_i.op == OP_PROGRAM && req_i.addr >= PROT_LIMIT)
        |=> (gnt_valid_o && gnt_o.addr == $past(req_i.addr) && gnt_o.data == $past(req_i.data)));

    // R6: erase requests are always forwarded
    a_r6_erase_forwarded: assert property (@(posedge clk) disable iff (por || srst)
        (req_valid_i && req_i.op == OP_ERASE) |=> (gnt_valid_o && gnt_o.op == OP_ERASE));

    // R11: soft reset empties the request output
    a_r11_srst_clears_gnt: assert property (@(posedge clk) disable iff (por)
        srst |=> !gnt_valid_o);
endmodule

// File: rtl/bootlock_id_mux.sv
module bootlock_id_mux
    import bootlock_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              srst,
    input  logic              locked_i,
    input  logic              id_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] arr_data_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] next_word;

    always_comb begin
        next_word = id_mode_i ? id_word(addr_i, locked_i) : arr_data_i;
    end

    always_ff @(posedge clk) begin
        if (por || srst) data_o <= '0;
        else             data_o <= next_word;
    end

    // R7: array data passes through outside identification mode
    a_r7_array_pass: assert property (@(posedge clk) disable iff (por || srst)
        !id_mode_i |=> data_o == $past(arr_data_i));

    // R8: manufacturer code at address 0
    a_r8_mfr_code: assert property (@(posedge clk) disable iff (por || srst)
        (id_mode_i && addr_i == ID_MFR_ADDR) |=> data_o == MFR_CODE);

    // R9: lock state at address 2, upper bits zero
    a_r9_lock_readback: assert property (@(posedge clk) disable iff (por || srst)
        (id_mode_i && addr_i == ID_LOCK_ADDR)
        |=> (data_o[DATA_W-1:1] == '0 && data_o[0] == $past(locked_i)));

    // R10: unused identification addresses read zero
    a_r10_id_zero: assert property (@(posedge clk) disable iff (por || srst)
        (id_mode_i && addr_i > ID_LOCK_ADDR) |=> data_o == '0);

    // R11: soft reset clears the read register
    a_r11_srst_clears_rd: assert property (@(posedge clk) disable iff (por)
        srst |=> data_o == '0);
endmodule

// File: rtl/bootlock_guard.sv
module bootlock_guard
    import bootlock_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              srst,
    input  logic              lock_set,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_rd_data,
    input  logic              req_valid,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              gnt_valid,
    output logic              gnt_erase,
    output logic [ADDR_W-1:0] gnt_addr,
    output logic [DATA_W-1:0] gnt_data,
    output logic              erase_mask,
    output logic [DATA_W-1:0] rd_data
);
    logic locked;
    req_t req_in;
    req_t gnt_out;

    always_comb begin
        req_in.op   = req_erase ? OP_ERASE : OP_PROGRAM;
        req_in.addr = req_addr;
        req_in.data = req_data;
    end

    bootlock_flag u_flag (
        .clk      (clk),
        .por      (por),
        .set_i    (lock_set),
        .locked_o (locked)
    );

    bootlock_req_gate u_gate (
        .clk         (clk),
        .por         (por),
        .srst        (srst),
        .locked_i    (locked),
        .req_valid_i (req_valid),
        .req_i       (req_in),
        .gnt_valid_o (gnt_valid),
        .gnt_o       (gnt_out)
    );

    bootlock_id_mux u_idmux (
        .clk        (clk),
        .por        (por),
        .srst       (srst),
        .locked_i   (locked),
        .id_mode_i  (id_mode),
        .addr_i     (rd_addr),
        .arr_data_i (arr_rd_data),
        .data_o     (rd_data)
    );

    assign gnt_erase  = (gnt_out.op == OP_ERASE);
    assign gnt_addr   = gnt_out.addr;
    assign gnt_data   = gnt_out.data;
    assign erase_mask = locked;

    // R2: power-on reset leaves everything idle and unlocked
    a_r2_por_idle: assert property (@(posedge clk)
        por |=> (!erase_mask && !gnt_valid && rd_data == '0));

    // R3: soft reset never drops the mask
    a_r3_srst_keeps_mask: assert property (@(posedge clk) disable iff (por)
        (srst && erase_mask) |=> erase_mask);
endmodule

// File: tb/bootlock_guard_test.sv
module bootlock_guard_test;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        srst = 1'b0;
    logic        lock_set = 1'b0;
    logic        id_mode = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [7:0]  arr_rd_data = '0;
    logic        req_valid = 1'b0;
    logic        req_erase = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        gnt_valid;
    logic        gnt_erase;
    logic [15:0] gnt_addr;
    logic [7:0]  gnt_data;
    logic        erase_mask;
    logic [7:0]  rd_data;

    always #10 clk = ~clk;

    bootlock_guard uut (
        .clk(clk), .por(por), .srst(srst), .lock_set(lock_set), .id_mode(id_mode),
        .rd_addr(rd_addr), .arr_rd_data(arr_rd_data), .req_valid(req_valid),
        .req_erase(req_erase), .req_addr(req_addr), .req_data(req_data),
        .gnt_valid(gnt_valid), .gnt_erase(gnt_erase), .gnt_addr(gnt_addr),
        .gnt_data(gnt_data), .erase_mask(erase_mask), .rd_data(rd_data)
    );

    typedef struct {
        string       tag;
        logic        gv;
        logic        ge;
        logic [15:0] ga;
        logic [7:0]  gd;
        logic        mask;
        logic [7:0]  rd;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    logic m_lock = 1'b0;
    logic done = 1'b0;

    task automatic step(input string tag, input logic p, input logic s, input logic lk,
                        input logic idm, input logic [15:0] ra, input logic [7:0] ad,
                        input logic rv, input logic re, input logic [15:0] qa,
                        input logic [7:0] qd);
        exp_t e;
        logic blocked;
        @(negedge clk);
        por = p; srst = s; lock_set = lk; id_mode = idm; rd_addr = ra;
        arr_rd_data = ad; req_valid = rv; req_erase = re; req_addr = qa; req_data = qd;
        e.tag = tag; e.ge = re; e.ga = qa; e.gd = qd;
        if (p) begin
            e.gv = 1'b0; e.rd = 8'h00; m_lock = 1'b0;
        end else if (s) begin
            e.gv = 1'b0; e.rd = 8'h00; m_lock = m_lock | lk;
        end else begin
            // window is 0000..1FFF
            blocked = rv && !re && m_lock && (qa <= 16'h1FFF);
            e.gv = rv && !blocked;
            if (!idm)             e.rd = ad;
            else if (ra == 16'd0) e.rd = 8'h1F;
            else if (ra == 16'd1) e.rd = 8'h03;
            else if (ra == 16'd2) e.rd = {7'b0, m_lock};
            else                  e.rd = 8'h00;
            m_lock = m_lock | lk;
        end
        e.mask = m_lock;
        q.push_back(e);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                logic bad;
                e = q.pop_front();
                n_run++;
                bad = (gnt_valid !== e.gv) || (erase_mask !== e.mask) || (rd_data !== e.rd);
                if (e.gv && ((gnt_erase !== e.ge) || (gnt_addr !== e.ga) || (gnt_data !== e.gd)))
                    bad = 1'b1;
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: got gv=%b ge=%b ga=%h gd=%h mask=%b rd=%h, expected gv=%b ge=%b ga=%h gd=%h mask=%b rd=%h",
                             e.tag, gnt_valid, gnt_erase, gnt_addr, gnt_data, erase_mask, rd_data,
                             e.gv, e.ge, e.ga, e.gd, e.mask, e.rd);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                n_fail++;
                n_run++;
                $display("FAIL watchdog: got timeout, expected completion");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        //    tag          por  srst lock idm rd_addr  arr    rv  re  req_addr  data
        step("R2 por",      1, 0, 0, 0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00);
        step("R5 unlocked", 0, 0, 0, 0, 16'h0000, 8'h3C, 1, 0, 16'h0100, 8'hA5);
        step("R7 array",    0, 0, 0, 0, 16'h0044, 8'hC3, 0, 0, 16'h0000, 8'h00);
        step("R8 mfr",      0, 0, 0, 1, 16'h0000, 8'h77, 0, 0, 16'h0000, 8'h00);
        step("R8 dev",      0, 0, 0, 1, 16'h0001, 8'h77, 0, 0, 16'h0000, 8'h00);
        step("R9 unlocked", 0, 0, 0, 1, 16'h0002, 8'hFF, 0, 0, 16'h0000, 8'h00);
        step("R10 addr3",   0, 0, 0, 1, 16'h0003, 8'hFF, 0, 0, 16'h0000, 8'h00);
        step("R10 top",     0, 0, 0, 1, 16'hFFFF, 8'hFF, 0, 0, 16'h0000, 8'h00);
        step("R3 set",      0, 0, 1, 0, 16'h0000, 8'h11, 1, 0, 16'h0010, 8'h5A);
        step("R4 low",      0, 0, 0, 0, 16'h0000, 8'h22, 1, 0, 16'h0000, 8'h00);
        step("R1 edge in",  0, 0, 0, 0, 16'h0000, 8'h22, 1, 0, 16'h1FFF, 8'h12);
        step("R1 edge out", 0, 0, 0, 0, 16'h0000, 8'h22, 1, 0, 16'h2000, 8'h34);
        step("R5 high",     0, 0, 0, 0, 16'h0000, 8'h22, 1, 0, 16'hFFFF, 8'h56);
        step("R6 erase",    0, 0, 0, 0, 16'h0000, 8'h22, 1, 1, 16'h0000, 8'h00);
        step("R9 locked",   0, 0, 0, 1, 16'h0002, 8'h00, 0, 0, 16'h0000, 8'h00);
        step("R11 srst",    0, 1, 0, 1, 16'h0000, 8'h99, 1, 0, 16'h4000, 8'h01);
        step("R3 kept",     0, 0, 0, 0, 16'h0000, 8'h98, 1, 0, 16'h1000, 8'h02);
        step("R3 reset",    0, 0, 1, 0, 16'h0000, 8'h97, 0, 0, 16'h0000, 8'h00);
        step("R7 back",     0, 0, 0, 0, 16'h1234, 8'h5E, 0, 0, 16'h0000, 8'h00);
        step("R2 por2",     1, 0, 0, 0, 16'h0000, 8'h00, 1, 0, 16'h0000, 8'h00);
        step("R5 blank",    0, 0, 0, 0, 16'h0000, 8'h00, 1, 0, 16'h0000, 8'h0F);
        step("R9 blank",    0, 0, 0, 1, 16'h0002, 8'h00, 0, 0, 16'h0000, 8'h00);
        step("R6 idle",     0, 0, 0, 0, 16'h0000, 8'h00, 1, 1, 16'h0000, 8'h00);
        step("R10 idle",    0, 0, 0, 0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00);
        @(posedge clk);
        #8;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule